// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple host request port to an asynchronous DRAM device whose row and column addresses share one group of address pins. Each accepted host request carries a flat word address, which the controller cuts into a row part (upper bits) and a column part (lower bits). It presents the row, drops the row strobe, switches the pins to the column and drops the column strobe. The column strobe also acts as the device's output enable, so read data is taken from the data pins while it is low. At the end, both strobes return high for a precharge interval.

Alongside host traffic, a free-running interval counter requests refresh. A refresh presents a row taken from an internal counter and pulses only the row strobe. The controller arbitrates refresh against host requests. A pending refresh is taken before a new request, but it never breaks into an access that has already started. Every strobe and the address pins come straight from registers. The data pins are driven only while the column strobe is low during a write.

Top module: `dram_mux_ctrl`

## Requirements
- R1: A host address is split with bits [21:11] as the row and bits [10:0] as the column. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls.
- R2: An access runs in this order. First come T_SETUP cycles with the row on the pins and both strobes high. Then come T_RCD cycles with `dram_ras_n` low. Then one cycle with the column on the pins and `dram_cas_n` still high. Then T_CAS cycles with both strobes low. Then T_PRE cycles with both strobes high.
- R3: For a read, `dram_we_n` stays high for the whole access. The value on `dram_dq` in the last cycle with `dram_cas_n` low is returned on `rd_data`, with `rd_valid` high for exactly one cycle: the first cycle after `dram_cas_n` rises.
- R4: For a write, `dram_we_n` is low from the first setup cycle through the last cycle with `dram_cas_n` low. `dram_dq` carries the request's write data only while `dram_cas_n` is low in a write, and is high-impedance at all other times.
- R5: `dram_cas_n` is never low while `dram_ras_n` is high.
- R6: A refresh holds `dram_cas_n` and `dram_we_n` high and keeps `dram_ras_n` low for T_RCD+1+T_CAS cycles. The address on the pins at the falling row strobe is the refresh row counter. The counter advances by one per refresh and starts at 0 after reset.
- R7: After row REF_ROWS-1 (1023 by default), the refresh row counter wraps to 0.
- R8: A refresh request arises every REF_INTERVAL cycles. With no host traffic, the row strobe of one refresh falls exactly REF_INTERVAL cycles after the previous one. Under continuous host traffic, the gap never exceeds REF_INTERVAL plus one access length plus one.
- R9: `req_ready` is high only when no access or refresh is in progress and no refresh is pending. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its strobe sequence starts on the next cycle.
- R10: After reset, all three strobes are high, `dram_dq` is high-impedance, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 22 | Word address, row in upper half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data available |
| rd_data | output | 8 | Read data |
| dram_addr | output | 11 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and output enable, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | 8 | Bidirectional data pins |

## Verification
The hardest case to reach from the ports is a refresh request that comes due while a host request is already waiting or an access is in flight. In that case the refresh must win arbitration without cutting the access short. The stimulus holds `req_valid` high for a long run of back-to-back reads and writes, so that many refresh intervals expire during traffic. The cycle-accurate pin model flags any refresh that overlaps an access, and a bound on refresh spacing catches starvation. A long idle stretch afterwards drives more than REF_ROWS refreshes, which exercises the row counter wrap and the exact idle spacing.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE,
        ST_RSETUP,
        ST_RRAS
    } seq_state_e;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] host_addr,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);
    // Row occupies the upper bits, column the lower bits.
    assign row = host_addr[ROW_W+COL_W-1:COL_W];
    assign col = host_addr[COL_W-1:0];
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int REF_INTERVAL = 64,
    parameter int REF_ROWS     = 1024,
    parameter int ROW_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int IV_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    typedef struct packed {
        logic [IV_W-1:0]  iv;
        logic             pend;
        logic [ROW_W-1:0] row;
    } sched_t;

    sched_t sched_d, sched_q;

    always_comb begin
        sched_d = sched_q;
        // Free-running interval counter; its wrap raises a request.
        if (sched_q.iv == IV_W'(REF_INTERVAL - 1)) begin
            sched_d.iv   = '0;
            sched_d.pend = 1'b1;
        end else begin
            sched_d.iv = sched_q.iv + 1'b1;
        end
        if (ack) begin
            sched_d.pend = 1'b0;
            if (sched_q.row == ROW_W'(REF_ROWS - 1)) begin
                sched_d.row = '0;
            end else begin
                sched_d.row = sched_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sched_q <= '0;
        end else begin
            sched_q <= sched_d;
        end
    end

    assign pend = sched_q.pend;
    assign row  = sched_q.row;
endmodule

// File: rtl/dram_dq_port.sv
module dram_dq_port #(
    parameter int DATA_W = 8
) (
    inout  wire  [DATA_W-1:0] pad,
    input  logic              oe,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din
);
    assign pad = oe ? dout : {DATA_W{1'bz}};
    assign din = pad;
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 11,
    parameter int DATA_W       = 8,
    parameter int T_SETUP      = 1,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_PRE        = 2,
    parameter int REF_INTERVAL = 64,
    parameter int REF_ROWS     = 1024
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [ROW_W+COL_W-1:0]                req_addr,
    input  logic                                  req_write,
    input  logic [DATA_W-1:0]                     req_wdata,
    output logic                                  rd_valid,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                                  dram_ras_n,
    output logic                                  dram_cas_n,
    output logic                                  dram_we_n,
    inout  wire  [DATA_W-1:0]                     dram_dq
);
    localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_RAS_REF = T_RCD + 1 + T_CAS;
    localparam int T_A       = (T_SETUP > T_PRE) ? T_SETUP : T_PRE;
    localparam int T_MAX     = (T_A > T_RAS_REF) ? T_A : T_RAS_REF;
    localparam int CNT_W     = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [PIN_W-1:0]  pin_addr;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              dq_oe;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: ST_IDLE, cnt: '0, row: '0, col: '0, wr: 1'b0, wdata: '0,
        pin_addr: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0,
        rd_valid: 1'b0, rd_data: '0
    };

    ctrl_t ctrl_d, ctrl_q;

    logic [ROW_W-1:0]  split_row;
    logic [COL_W-1:0]  split_col;
    logic              ref_pend;
    logic              ref_ack;
    logic [ROW_W-1:0]  ref_row;
    logic [DATA_W-1:0] dq_in;
    logic              dq_oe_w;

    dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) split_i (
        .host_addr (req_addr),
        .row       (split_row),
        .col       (split_col)
    );

    dram_refresh_sched #(
        .REF_INTERVAL (REF_INTERVAL),
        .REF_ROWS     (REF_ROWS),
        .ROW_W        (ROW_W)
    ) sched_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend),
        .row   (ref_row)
    );

    dram_dq_port #(.DATA_W(DATA_W)) dq_i (
        .pad  (dram_dq),
        .oe   (ctrl_q.dq_oe),
        .dout (ctrl_q.wdata),
        .din  (dq_in)
    );

    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.rd_valid = 1'b0;
        ref_ack         = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    // Refresh has priority over a new host request.
                    ref_ack         = 1'b1;
                    ctrl_d.st       = ST_RSETUP;
                    ctrl_d.cnt      = CNT_W'(T_SETUP - 1);
                    ctrl_d.pin_addr = PIN_W'(ref_row);
                end else if (req_valid) begin
                    ctrl_d.st       = ST_SETUP;
                    ctrl_d.cnt      = CNT_W'(T_SETUP - 1);
                    ctrl_d.row      = split_row;
                    ctrl_d.col      = split_col;
                    ctrl_d.wr       = req_write;
                    ctrl_d.wdata    = req_wdata;
                    ctrl_d.pin_addr = PIN_W'(split_row);
                    ctrl_d.we_n     = ~req_write;
                end
            end
            ST_SETUP: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st    = ST_RAS;
                    ctrl_d.cnt   = CNT_W'(T_RCD - 1);
                    ctrl_d.ras_n = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_RAS: begin
                if (ctrl_q.cnt == '0) begin
                    // One cycle of column setup before the column strobe.
                    ctrl_d.st       = ST_COL;
                    ctrl_d.pin_addr = PIN_W'(ctrl_q.col);
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                ctrl_d.st    = ST_CAS;
                ctrl_d.cnt   = CNT_W'(T_CAS - 1);
                ctrl_d.cas_n = 1'b0;
                ctrl_d.dq_oe = ctrl_q.wr;
            end
            ST_CAS: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st    = ST_PRE;
                    ctrl_d.cnt   = CNT_W'(T_PRE - 1);
                    ctrl_d.ras_n = 1'b1;
                    ctrl_d.cas_n = 1'b1;
                    ctrl_d.we_n  = 1'b1;
                    ctrl_d.dq_oe = 1'b0;
                    if (!ctrl_q.wr) begin
                        ctrl_d.rd_valid = 1'b1;
                        ctrl_d.rd_data  = dq_in;
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st = ST_IDLE;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_RSETUP: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st    = ST_RRAS;
                    ctrl_d.cnt   = CNT_W'(T_RAS_REF - 1);
                    ctrl_d.ras_n = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            ST_RRAS: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st    = ST_PRE;
                    ctrl_d.cnt   = CNT_W'(T_PRE - 1);
                    ctrl_d.ras_n = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: begin
                ctrl_d = CTRL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready  = (ctrl_q.st == ST_IDLE) && !ref_pend;
    assign rd_valid   = ctrl_q.rd_valid;
    assign rd_data    = ctrl_q.rd_data;
    assign dram_addr  = ctrl_q.pin_addr;
    assign dram_ras_n = ctrl_q.ras_n;
    assign dram_cas_n = ctrl_q.cas_n;
    assign dram_we_n  = ctrl_q.we_n;
    assign dq_oe_w    = ctrl_q.dq_oe;

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
    parameter int ROW_W    = 11,
    parameter int PIN_W    = 11,
    parameter int REF_ROWS = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIN_W-1:0] pin_addr,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             rd_valid,
    input logic             req_ready,
    input logic             ref_pend,
    input logic             ref_ack,
    input logic [ROW_W-1:0] ref_row
);
    assert_row_held_at_ras_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(pin_addr));

    assert_we_steady_in_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> $stable(we_n));

    assert_read_follows_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!cas_n) && $past(we_n)));

    assert_read_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_dq_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!cas_n && !we_n));

    assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_row_counter_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ack && (ref_row == ROW_W'(REF_ROWS - 1))) |=> (ref_row == '0));

    assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

    assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && cas_n && we_n));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
    .ROW_W    (ROW_W),
    .PIN_W    (PIN_W),
    .REF_ROWS (REF_ROWS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_addr  (dram_addr),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .dq_oe     (dq_oe_w),
    .rd_valid  (rd_valid),
    .req_ready (req_ready),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .ref_row   (ref_row)
);

// File: tb/dram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb_top;
    localparam int ROW_W    = 11;
    localparam int COL_W    = 11;
    localparam int DW       = 8;
    localparam int AW       = ROW_W + COL_W;
    localparam int T_SETUP  = 1;
    localparam int T_RCD    = 2;
    localparam int T_CAS    = 2;
    localparam int T_PRE    = 2;
    localparam int REF_INT  = 24;
    localparam int REF_ROWS = 1024;
    localparam int ACC_LEN  = T_SETUP + T_RCD + 1 + T_CAS + T_PRE;
    localparam int WD_CYC   = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_write;
    logic [DW-1:0] req_wdata;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [10:0]   dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n;
    wire  [DW-1:0] dram_dq;

    always #10 clk = ~clk;

    dram_mux_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_SETUP(T_SETUP),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE),
        .REF_INTERVAL(REF_INT), .REF_ROWS(REF_ROWS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq(dram_dq)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Device model: latches row and column on strobe falls, drives on read.
    logic [DW-1:0]    dev_mem [logic [AW-1:0]];
    logic [ROW_W-1:0] dev_row;
    logic [COL_W-1:0] dev_col;
    logic [DW-1:0]    dev_val;

    always @(negedge dram_ras_n) dev_row = dram_addr;
    always @(negedge dram_cas_n) begin
        dev_col = dram_addr;
        dev_val = dev_mem.exists({dev_row, dev_col}) ? dev_mem[{dev_row, dev_col}]
                                                     : pat({dev_row, dev_col});
    end
    assign dram_dq = (!dram_cas_n && dram_we_n) ? dev_val : {DW{1'bz}};

    // Reference model: expected pins per cycle for accepted host accesses.
    typedef struct {
        logic [10:0]   addr;
        bit            ras, cas, we, drv, rdv;
        logic [DW-1:0] data;
    } exp_t;

    exp_t          expq[$];
    exp_t          e;
    logic [DW-1:0] exp_mem [logic [AW-1:0]];
    int            cyc = 0;
    int            ref_cnt = 0;
    int            exp_row = 0;
    bit            in_ref = 0;
    int            ref_len = 0;
    int            last_fall = 0;
    bit            have_last = 0;
    bit            host_act = 0;
    bit            prev_clean = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                check(dram_ras_n == e.ras && dram_cas_n == e.cas, "R2", "strobes",
                      {dram_ras_n, dram_cas_n}, {e.ras, e.cas});
                check(dram_addr == e.addr, "R1", "pin address", dram_addr, e.addr);
                check(dram_we_n == e.we, e.we ? "R3" : "R4", "we_n", dram_we_n, e.we);
                if (e.drv)
                    check(dram_dq === e.data, "R4", "write data on dq", dram_dq, e.data);
                else if (e.cas)
                    check(dram_dq === {DW{1'bz}}, "R4", "dq released", dram_dq, 0);
                check(rd_valid == e.rdv, "R3", "rd_valid", rd_valid, e.rdv);
                if (e.rdv)
                    check(rd_data == e.data, "R3", "rd_data", rd_data, e.data);
                check(!req_ready, "R9", "ready during access", req_ready, 0);
                if (!dram_cas_n && !dram_we_n && !dram_ras_n)
                    dev_mem[{dev_row, dev_col}] = dram_dq;
            end else begin
                if (!dram_ras_n) begin
                    if (!in_ref) begin
                        in_ref  = 1;
                        ref_len = 0;
                        check(dram_addr == 11'(exp_row), "R6", "refresh row",
                              dram_addr, exp_row);
                        if (exp_row == 0 && ref_cnt > 0)
                            check(dram_addr == 0, "R7", "row wrap", dram_addr, 0);
                        if (have_last) begin
                            if (prev_clean && !host_act)
                                check(cyc - last_fall == REF_INT, "R8", "idle spacing",
                                      cyc - last_fall, REF_INT);
                            check(cyc - last_fall <= REF_INT + ACC_LEN + 1, "R8",
                                  "spacing bound", cyc - last_fall, REF_INT + ACC_LEN + 1);
                        end
                        prev_clean = !host_act;
                        host_act   = 0;
                        last_fall  = cyc;
                        have_last  = 1;
                        exp_row    = (exp_row == REF_ROWS - 1) ? 0 : exp_row + 1;
                        ref_cnt++;
                    end
                    ref_len++;
                    check(dram_cas_n && dram_we_n, "R6", "refresh cas/we high",
                          {dram_cas_n, dram_we_n}, 2'b11);
                end else begin
                    if (in_ref) begin
                        in_ref = 0;
                        check(ref_len == T_RCD + 1 + T_CAS, "R6", "refresh ras width",
                              ref_len, T_RCD + 1 + T_CAS);
                    end
                    check(dram_cas_n && dram_we_n && !rd_valid, "R5", "idle strobes",
                          {dram_cas_n, dram_we_n, rd_valid}, 3'b110);
                end
                check(dram_dq === {DW{1'bz}}, "R4", "dq idle high-Z", dram_dq, 0);
            end
            if (req_valid && req_ready) begin
                host_act = 1;
                e.ras = 1; e.cas = 1; e.we = !req_write; e.drv = 0; e.rdv = 0;
                e.data = req_wdata;
                e.addr = req_addr[AW-1:COL_W];
                for (int i = 0; i < T_SETUP; i++) expq.push_back(e);
                e.ras = 0;
                for (int i = 0; i < T_RCD; i++) expq.push_back(e);
                e.addr = req_addr[COL_W-1:0];
                expq.push_back(e);
                e.cas = 0; e.drv = req_write;
                for (int i = 0; i < T_CAS; i++) expq.push_back(e);
                e.ras = 1; e.cas = 1; e.we = 1; e.drv = 0;
                if (req_write) begin
                    exp_mem[req_addr] = req_wdata;
                end else begin
                    e.rdv  = 1;
                    e.data = exp_mem.exists(req_addr) ? exp_mem[req_addr] : pat(req_addr);
                end
                for (int i = 0; i < T_PRE; i++) begin
                    expq.push_back(e);
                    e.rdv = 0;
                end
            end
        end
    end

    task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit acc;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
            #1;
        end while (!acc);
    endtask

    task automatic host_drain();
        req_valid = 1'b0;
        do @(negedge clk); while (expq.size() > 0);
    endtask

    initial begin
        #(WD_CYC * 20);
        check(0, "R8", "watchdog expired", cyc, WD_CYC);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(dram_ras_n && dram_cas_n && dram_we_n, "R10", "reset strobes",
              {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
        check(dram_dq === {DW{1'bz}}, "R10", "reset dq", dram_dq, 0);
        check(!rd_valid && req_ready, "R10", "reset rd_valid/ready",
              {rd_valid, req_ready}, 2'b01);
        @(posedge clk); #1;

        // R1 R4: writes at address extremes and alternating patterns
        host_op(1, {11'h7FF, 11'h7FF}, 8'hA5); host_drain();
        host_op(1, 22'h0, 8'h3C);              host_drain();
        host_op(1, {11'h555, 11'h2AA}, 8'h96); host_drain();
        // R3: reads back, plus an unwritten location
        host_op(0, {11'h7FF, 11'h7FF}, 8'h00); host_drain();
        host_op(0, 22'h0, 8'h00);              host_drain();
        host_op(0, {11'h555, 11'h2AA}, 8'h00); host_drain();
        host_op(0, 22'h12345, 8'h00);          host_drain();

        // R8 R9: continuous traffic so refresh competes with waiting requests
        for (int i = 0; i < 300; i++) begin
            host_op(i[0], AW'(i * 37) ^ {11'(i), 11'h0}, 8'(i * 13));
        end
        host_drain();
        host_op(0, AW'(5 * 37) ^ {11'(5), 11'h0}, 8'h00); host_drain();

        // R6 R7: idle until the refresh row counter has wrapped
        while (ref_cnt < REF_ROWS + 6) @(negedge clk);
        check(ref_cnt >= REF_ROWS + 6, "R7", "refresh count after wrap", ref_cnt, REF_ROWS + 6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule